// File: doc/BRIEF.md
# I2C Master SCL Phase Generator

This block sets the timing of the SCL clock for an I2C master. It runs from the peripheral clock. A 12-bit divider scales one of three low:high ratios: 1:1 in standard mode, and 2:1 or 16:9 in fast mode. The block pulls SCL low for the low phase and then releases it. It does not count the high phase until SCL is seen high, so a slave that stretches the clock is honoured. A rise-time bound limits how long it waits for that. The bound is derived from the peripheral clock frequency in MHz.

The bit-level sequencer uses three outputs. `low_phase` and `high_phase` mark the two halves of each SCL period. `mid_tick` is a one-cycle strobe at the middle of the high phase, and the sequencer samples SDA on it. Software may write the timing inputs at any time. The block captures them only while `en` is low, and it holds the captured set for the whole time it is enabled.

The controller has four states:
- `ST_IDLE`: SCL is released and the counter is clear.
- `ST_LOW`: SCL is pulled low for the low length.
- `ST_RISE`: SCL is released and the block waits for it to read high, or for the rise bound to expire.
- `ST_HIGH`: the high length is counted.

The transitions are:
- IDLE→LOW when enabled.
- LOW→RISE when the low count is done.
- RISE→HIGH when SCL reads high or the bound expires.
- HIGH→LOW when the high count is done.
- Any state→IDLE when `en` is low or on reset.

Top module: `scl_phase_gen`

## Requirements
- R1: When `rst` is high or `en` is low at a clock edge, the block is in IDLE after that edge. In IDLE, `scl_pull`, `low_phase`, `high_phase` and `mid_tick` are all 0, and the phase counter is clear.
- R2: Standard mode (`fast_mode`=0) gives a low phase and a high phase of E cycles each, where E = max(`divider`,4). `duty_16_9` has no effect in this mode.
- R3: Fast mode with `duty_16_9`=0 gives a low phase of 2·E and a high phase of E, where E = max(`divider`,1).
- R4: Fast mode with `duty_16_9`=1 gives a low phase of 16·E and a high phase of 9·E, where E = max(`divider`,1).
- R5: In standard mode, a divider below 4 acts as 4. In fast mode, a divider of 0 acts as 1.
- R6: After the low phase, SCL is released (RISE) for at least one cycle. The high phase begins in the cycle after `scl_in` is sampled high in RISE.
- R7: If `scl_in` stays low, RISE lasts L cycles and then the high phase begins anyway. L = F+1 in standard mode and floor(3·F/10)+1 in fast mode, where F is `pclk_mhz` clamped to the range 2..36.
- R8: Each high phase carries exactly one `mid_tick` cycle, at offset floor(H/2) from its first cycle, where H is the high length.
- R9: The timing inputs are captured at every edge where `en` is low. Changes made to them while `en` is high have no effect on the phase lengths.
- R10: The first low phase starts in the cycle after `en` is sampled high. While enabled, the phases repeat as LOW, RISE, HIGH, LOW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Generator enable; timing inputs are captured while low |
| pclk_mhz | input | 6 | Peripheral clock frequency in MHz |
| divider | input | 12 | Phase divider |
| fast_mode | input | 1 | 1 = fast mode, 0 = standard mode |
| duty_16_9 | input | 1 | In fast mode, 1 selects the 16:9 ratio and 0 selects 2:1 |
| scl_in | input | 1 | Sampled level of the SCL line |
| scl_pull | output | 1 | 1 = drive SCL low, 0 = release |
| low_phase | output | 1 | SCL low phase in progress |
| high_phase | output | 1 | SCL high phase being counted |
| mid_tick | output | 1 | One-cycle strobe at the middle of the high phase |

## Verification
The hardest case to reach is a RISE wait that ends on the timeout rather than on SCL going high. It only happens when a slave holds the line low for longer than the bound, and the bound depends on both the mode and the clamped frequency. The bench models the line as released whenever `scl_pull` is 0, unless a stretch flag holds it low. Directed runs hold the line low through the whole wait, at low, mid-range and out-of-range frequencies in both modes. Random runs mix stretched and free releases.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_RISE = 2'd2,
        ST_HIGH = 2'd3
    } scl_state_e;

    localparam int STD_MIN_DIV  = 4;
    localparam int FAST_MIN_DIV = 1;
    localparam int FREQ_MIN     = 2;
    localparam int FREQ_MAX     = 36;
    localparam int LOW_MUL_21   = 2;
    localparam int LOW_MUL_169  = 16;
    localparam int HIGH_MUL_169 = 9;
endpackage

// File: rtl/scl_cfg_regs.sv
module scl_cfg_regs
    import scl_gen_pkg::*;
#(
    parameter int DIV_W  = 12,
    parameter int FREQ_W = 6,
    parameter int CNT_W  = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [FREQ_W-1:0] pclk_mhz,
    input  logic [DIV_W-1:0]  divider,
    input  logic              fast_mode,
    input  logic              duty_16_9,
    output logic [CNT_W-1:0]  low_len,
    output logic [CNT_W-1:0]  high_len,
    output logic [CNT_W-1:0]  rise_lim
);
    logic [FREQ_W-1:0] freq_q;
    logic [DIV_W-1:0]  div_q;
    logic              fast_q;
    logic              duty_q;

    // capture only while the generator is disabled
    always_ff @(posedge clk) begin
        if (rst) begin
            freq_q <= '0;
            div_q  <= '0;
            fast_q <= 1'b0;
            duty_q <= 1'b0;
        end else if (!en) begin
            freq_q <= pclk_mhz;
            div_q  <= divider;
            fast_q <= fast_mode;
            duty_q <= duty_16_9;
        end
    end

    logic [CNT_W-1:0] eff;
    logic [CNT_W-1:0] f_clamped;

    always_comb begin
        eff = CNT_W'(div_q);
        if (fast_q) begin
            if (div_q < DIV_W'(FAST_MIN_DIV)) eff = CNT_W'(FAST_MIN_DIV);
        end else begin
            if (div_q < DIV_W'(STD_MIN_DIV)) eff = CNT_W'(STD_MIN_DIV);
        end

        f_clamped = CNT_W'(freq_q);
        if (freq_q < FREQ_W'(FREQ_MIN)) f_clamped = CNT_W'(FREQ_MIN);
        else if (freq_q > FREQ_W'(FREQ_MAX)) f_clamped = CNT_W'(FREQ_MAX);

        if (fast_q && duty_q) begin
            low_len  = eff * CNT_W'(LOW_MUL_169);
            high_len = eff * CNT_W'(HIGH_MUL_169);
        end else if (fast_q) begin
            low_len  = eff * CNT_W'(LOW_MUL_21);
            high_len = eff;
        end else begin
            low_len  = eff;
            high_len = eff;
        end

        if (fast_q) rise_lim = (f_clamped * CNT_W'(3)) / CNT_W'(10) + CNT_W'(1);
        else        rise_lim = f_clamped + CNT_W'(1);
    end
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_gen_pkg::*;
#(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             scl_in,
    input  logic [CNT_W-1:0] low_len,
    input  logic [CNT_W-1:0] high_len,
    input  logic [CNT_W-1:0] rise_lim,
    output logic             scl_pull,
    output logic             low_phase,
    output logic             high_phase,
    output logic             mid_tick
);
    scl_state_e       state, nxt_state;
    logic [CNT_W-1:0] cnt, nxt_cnt;

    always_comb begin
        nxt_state = state;
        nxt_cnt   = cnt + CNT_W'(1);
        if (!en) begin
            nxt_state = ST_IDLE;
            nxt_cnt   = '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    nxt_state = ST_LOW;
                    nxt_cnt   = '0;
                end
                ST_LOW: begin
                    if (cnt == low_len - CNT_W'(1)) begin
                        nxt_state = ST_RISE;
                        nxt_cnt   = '0;
                    end
                end
                ST_RISE: begin
                    if (scl_in || cnt == rise_lim - CNT_W'(1)) begin
                        nxt_state = ST_HIGH;
                        nxt_cnt   = '0;
                    end
                end
                ST_HIGH: begin
                    if (cnt == high_len - CNT_W'(1)) begin
                        nxt_state = ST_LOW;
                        nxt_cnt   = '0;
                    end
                end
                default: begin
                    nxt_state = ST_IDLE;
                    nxt_cnt   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt_state;
            cnt   <= nxt_cnt;
        end
    end

    always_comb begin
        scl_pull   = 1'b0;
        low_phase  = 1'b0;
        high_phase = 1'b0;
        mid_tick   = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_LOW: begin
                scl_pull  = 1'b1;
                low_phase = 1'b1;
            end
            ST_RISE: ;
            ST_HIGH: begin
                high_phase = 1'b1;
                mid_tick   = (cnt == (high_len >> 1));
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen
    import scl_gen_pkg::*;
#(
    parameter int DIV_W  = 12,
    parameter int FREQ_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [FREQ_W-1:0] pclk_mhz,
    input  logic [DIV_W-1:0]  divider,
    input  logic              fast_mode,
    input  logic              duty_16_9,
    input  logic              scl_in,
    output logic              scl_pull,
    output logic              low_phase,
    output logic              high_phase,
    output logic              mid_tick
);
    localparam int CNT_W = DIV_W + 5;

    logic [CNT_W-1:0] low_len_w;
    logic [CNT_W-1:0] high_len_w;
    logic [CNT_W-1:0] rise_lim_w;

    scl_cfg_regs #(.DIV_W(DIV_W), .FREQ_W(FREQ_W), .CNT_W(CNT_W)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .pclk_mhz  (pclk_mhz),
        .divider   (divider),
        .fast_mode (fast_mode),
        .duty_16_9 (duty_16_9),
        .low_len   (low_len_w),
        .high_len  (high_len_w),
        .rise_lim  (rise_lim_w)
    );

    scl_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .scl_in     (scl_in),
        .low_len    (low_len_w),
        .high_len   (high_len_w),
        .rise_lim   (rise_lim_w),
        .scl_pull   (scl_pull),
        .low_phase  (low_phase),
        .high_phase (high_phase),
        .mid_tick   (mid_tick)
    );
endmodule

// File: rtl/scl_phase_chk.sv
module scl_phase_chk #(
    parameter int CNT_W = 17
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             scl_pull,
    input logic             low_phase,
    input logic             high_phase,
    input logic             mid_tick,
    input logic [CNT_W-1:0] low_len
);
    // R1
    disable_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!scl_pull && !low_phase && !high_phase && !mid_tick));

    // R8
    tick_in_high_chk: assert property (@(posedge clk) disable iff (rst)
        mid_tick |-> high_phase);

    // R6
    rise_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(low_phase) |-> !high_phase);

    // R10
    high_to_low_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(high_phase) && $past(en)) |-> low_phase);

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(en) && !$past(rst)) |-> $stable(low_len));
endmodule

bind scl_phase_gen scl_phase_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .scl_pull   (scl_pull),
    .low_phase  (low_phase),
    .high_phase (high_phase),
    .mid_tick   (mid_tick),
    .low_len    (low_len_w)
);

// File: tb/sim_scl_phase_gen.sv
module sim_scl_phase_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [5:0]  pclk_mhz = 6'd8;
    logic [11:0] divider = 12'd0;
    logic        fast_mode = 1'b0;
    logic        duty_16_9 = 1'b0;
    logic        hold_low = 1'b0;
    logic        scl_in;
    logic        scl_pull, low_phase, high_phase, mid_tick;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;  // 125 MHz

    assign scl_in = ~(scl_pull | hold_low);

    scl_phase_gen u0 (
        .clk(clk), .rst(rst), .en(en), .pclk_mhz(pclk_mhz), .divider(divider),
        .fast_mode(fast_mode), .duty_16_9(duty_16_9), .scl_in(scl_in),
        .scl_pull(scl_pull), .low_phase(low_phase), .high_phase(high_phase),
        .mid_tick(mid_tick)
    );

    function automatic int exp_eff(int d, bit f);
        if (f) return (d < 1) ? 1 : d;
        return (d < 4) ? 4 : d;
    endfunction

    function automatic int exp_low(int d, bit f, bit y);
        int e = exp_eff(d, f);
        if (f && y) return 16 * e;
        if (f) return 2 * e;
        return e;
    endfunction

    function automatic int exp_high(int d, bit f, bit y);
        int e = exp_eff(d, f);
        if (f && y) return 9 * e;
        return e;
    endfunction

    function automatic int exp_lim(int fr, bit f);
        int c = (fr < 2) ? 2 : ((fr > 36) ? 36 : fr);
        if (f) return (c * 3) / 10 + 1;
        return c + 1;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic configure(int d, bit f, bit y, int fr);
        @(negedge clk);
        en = 1'b0;
        divider = 12'(d);
        fast_mode = f;
        duty_16_9 = y;
        pclk_mhz = 6'(fr);
        @(negedge clk);
        en = 1'b1;
    endtask

    task automatic measure(output int lo, output int gap, output int hi,
                           output int tpos, output int tcnt);
        @(negedge clk);
        while (low_phase) @(negedge clk);
        while (!low_phase) @(negedge clk);
        lo = 0;
        while (low_phase) begin lo++; @(negedge clk); end
        gap = 0;
        while (!high_phase) begin gap++; @(negedge clk); end
        hi = 0; tcnt = 0; tpos = -1;
        while (high_phase) begin
            if (mid_tick) begin tcnt++; tpos = hi; end
            hi++;
            @(negedge clk);
        end
    endtask

    task automatic run_case(string tag, int d, bit f, bit y, int fr, bit stretch);
        int lo, gap, hi, tpos, tcnt;
        hold_low = stretch;
        configure(d, f, y, fr);
        measure(lo, gap, hi, tpos, tcnt);
        check({tag, " R2/R3/R4 low length"}, lo, exp_low(d, f, y));
        check({tag, " R2/R3/R4 high length"}, hi, exp_high(d, f, y));
        if (stretch) check({tag, " R7 rise timeout"}, gap, exp_lim(fr, f));
        else         check({tag, " R6 rise wait"}, gap, 1);
        check({tag, " R8 tick count"}, tcnt, 1);
        check({tag, " R8 tick offset"}, tpos, exp_high(d, f, y) / 2);
        hold_low = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int lo, gap, hi, tpos, tcnt;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1 reset pull", int'(scl_pull), 0);
        check("R1 reset phases", int'(low_phase) + int'(high_phase) + int'(mid_tick), 0);

        // R10: first low starts one cycle after enable
        configure(10, 1'b0, 1'b0, 8);
        @(negedge clk);
        check("R10 first low", int'(low_phase), 1);
        check("R10 first pull", int'(scl_pull), 1);

        // R1: disable releases next cycle
        @(negedge clk); en = 1'b0;
        @(negedge clk);
        check("R1 disable release", int'(scl_pull) + int'(low_phase) + int'(high_phase), 0);

        // directed: standard, duty ignored, clamps (R5)
        run_case("std",       10, 1'b0, 1'b0, 8, 1'b0);
        run_case("std duty",  10, 1'b0, 1'b1, 8, 1'b0);
        run_case("R5 std0",    0, 1'b0, 1'b0, 8, 1'b0);
        run_case("R5 std3",    3, 1'b0, 1'b0, 8, 1'b0);
        run_case("R5 fast0",   0, 1'b1, 1'b0, 8, 1'b0);
        run_case("R5 fast169", 0, 1'b1, 1'b1, 8, 1'b0);
        run_case("fast21",     7, 1'b1, 1'b0, 8, 1'b0);
        run_case("fast169",    5, 1'b1, 1'b1, 8, 1'b0);
        // R7: timeout with clamped and unclamped frequencies
        run_case("R7 std20",   6, 1'b0, 1'b0, 20, 1'b1);
        run_case("R7 fast20",  6, 1'b1, 1'b0, 20, 1'b1);
        run_case("R7 std63",   5, 1'b0, 1'b0, 63, 1'b1);
        run_case("R7 fast0",   5, 1'b1, 1'b0, 0, 1'b1);
        run_case("R7 fast36",  4, 1'b1, 1'b1, 36, 1'b1);

        // R9: changes while enabled have no effect
        configure(6, 1'b0, 1'b0, 8);
        @(negedge clk);
        divider = 12'd40; fast_mode = 1'b1; duty_16_9 = 1'b1;
        measure(lo, gap, hi, tpos, tcnt);
        check("R9 low held", lo, 6);
        check("R9 high held", hi, 6);
        // R10: phases keep repeating
        measure(lo, gap, hi, tpos, tcnt);
        check("R10 repeat low", lo, 6);

        // random mix
        for (int i = 0; i < 16; i++) begin
            int d  = $urandom_range(0, 24);
            bit f  = 1'($urandom_range(0, 1));
            bit y  = 1'($urandom_range(0, 1));
            int fr = $urandom_range(0, 63);
            bit s  = 1'($urandom_range(0, 1));
            run_case("rand", d, f, y, fr, s);
        end

        // R1: synchronous reset while running
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        check("R1 reset running", int'(scl_pull) + int'(low_phase) + int'(high_phase), 0);
        rst = 1'b0; en = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule